// File: doc/BRIEF.md
# Sleep and Stop Power-Mode Controller

This block is the power-mode sequencer for a processor core. Single-cycle pulses from the core ask it to halt, which enters a light sleep, or to go to standby, which enters a deep stop. Wake-up inputs bring it back to running. A maskable interrupt is level sensitive, and an NMI counts only on its rising edge. Each low-power mode accepts its own set of wake sources. The block drives a PLL enable, a core clock enable and a 4-bit bus status code with its output enable.

The block also grants external bus-hold requests, and whether a request is granted depends on the mode. While a hold is granted, the status pins are released. When the hold ends, the halt-acknowledge code comes back on the next clock edge. After an NMI ends stop mode, the PLL turns on at once, but the core clock stays gated for a fixed lock interval.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset is asserted, the block is running: clk_en_o=1, pll_en_o=1, hold_ack_o=0, status_oe_o=1, status_o=IDLE_CODE (default 4'hF).
- R2: When halt_i is high at a clock edge while running, the block is in sleep from that edge on: clk_en_o=0, pll_en_o=1, status_o=HALT_CODE (default 4'hA).
- R3: When stby_i is high at a clock edge while running, the block is in stop from that edge on: clk_en_o=0, pll_en_o=0, status_o=HALT_CODE. stby_i takes priority over a halt_i in the same cycle.
- R4: Sleep returns to running at the first edge where irq_i is high, or where nmi_i is high after being low at the previous edge.
- R5: In stop, irq_i has no effect and the block stays in stop.
- R6: An NMI rising edge in stop sets pll_en_o=1 at that edge. clk_en_o stays 0 for exactly LOCK_CYCLES cycles from that edge, and running resumes after that.
- R7: A hold request is granted one edge after it is sampled while the block is in sleep. It is never granted in stop or during the lock wait.
- R8: While running, a hold request is granted only in cycles where bus_idle_i is high.
- R9: status_oe_o is low exactly while hold_ack_o is high. On the edge where the grant drops in sleep, status_oe_o=1 with status_o=HALT_CODE.
- R10: Asserting rst_ni from any mode, stop included, returns the outputs to the run state at once, without waiting for a clock.
- R11: An NMI that stays high does not wake stop again. A new wake needs a low sample followed by a high one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, also a wake source |
| halt_i | input | 1 | Halt instruction pulse |
| stby_i | input | 1 | Standby instruction pulse |
| irq_i | input | 1 | Maskable interrupt request, level |
| nmi_i | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| hold_req_i | input | 1 | External bus-hold request |
| bus_idle_i | input | 1 | Core reports no bus cycle in progress |
| hold_ack_o | output | 1 | Bus-hold acknowledge |
| pll_en_o | output | 1 | PLL enable |
| clk_en_o | output | 1 | Core clock gate enable |
| status_oe_o | output | 1 | Bus status output enable |
| status_o | output | 4 | Bus status code |

## Verification
A wrong mode register shows up on the clock and PLL enables and on the status code in the cycle after the edge that caused it. The bench therefore compares all outputs after every edge. A lock counter that ends too early or too late moves the rise of clk_en_o by a whole cycle, so the bench checks each cycle of the lock wait one by one. A grant decision made from the wrong state shows up as a one-cycle hold_ack_o pulse in stop, or as a status_oe_o that stays low for an extra edge after the hold request ends.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_LOCK  = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R11: a held level reports at most one edge
  assert_single_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_hold_arb.sv
module pwr_hold_arb
  import pwr_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwr_mode_e mode_d_i,
  input  logic      hold_req_i,
  input  logic      bus_idle_i,
  output logic      hold_ack_o
);
  logic grant_ok;

  always_comb begin
    unique case (mode_d_i)
      MODE_SLEEP: grant_ok = 1'b1;
      MODE_RUN:   grant_ok = bus_idle_i;
      default:    grant_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_ack_o <= 1'b0;
    else         hold_ack_o <= hold_req_i & grant_ok;
  end

  assert_ack_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> $past(hold_req_i));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 16,
  parameter logic [3:0]  HALT_CODE   = 4'hA,
  parameter logic [3:0]  IDLE_CODE   = 4'hF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       stby_i,
  input  logic       irq_i,
  input  logic       nmi_i,
  input  logic       hold_req_i,
  input  logic       bus_idle_i,
  output logic       hold_ack_o,
  output logic       pll_en_o,
  output logic       clk_en_o,
  output logic       status_oe_o,
  output logic [3:0] status_o
);
  pwr_mode_e mode_q, mode_d;
  logic nmi_rise, lock_done;

  pwr_edge_det u_nmi_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (nmi_i),
    .rise_o(nmi_rise)
  );

  pwr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode_q == MODE_LOCK),
    .done_o(lock_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:   if (stby_i) mode_d = MODE_STOP;
                  else if (halt_i) mode_d = MODE_SLEEP;
      MODE_SLEEP: if (irq_i || nmi_rise) mode_d = MODE_RUN;
      MODE_STOP:  if (nmi_rise) mode_d = MODE_LOCK;
      MODE_LOCK:  if (lock_done) mode_d = MODE_RUN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  pwr_hold_arb u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_d_i  (mode_d),
    .hold_req_i(hold_req_i),
    .bus_idle_i(bus_idle_i),
    .hold_ack_o(hold_ack_o)
  );

  assign pll_en_o    = (mode_q != MODE_STOP);
  assign clk_en_o    = (mode_q == MODE_RUN);
  assign status_oe_o = ~hold_ack_o;
  assign status_o    = (mode_q == MODE_SLEEP || mode_q == MODE_STOP) ? HALT_CODE : IDLE_CODE;

  assert_sleep_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && irq_i) |=> clk_en_o);
  assert_stop_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !nmi_rise) |=> !pll_en_o);
  assert_nmi_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && nmi_rise) |=> (pll_en_o && !clk_en_o));
  assert_no_ack_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_en_o || mode_q == MODE_LOCK) |-> !hold_ack_o);
  assert_status_back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_ack_o) && mode_q == MODE_SLEEP) |-> (status_oe_o && status_o == HALT_CODE));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 4;
  localparam logic [3:0] HC = 4'hA;
  localparam logic [3:0] IC = 4'hF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic halt_i = 0, stby_i = 0, irq_i = 0, nmi_i = 0, hold_req_i = 0, bus_idle_i = 0;
  logic hold_ack_o, pll_en_o, clk_en_o, status_oe_o;
  logic [3:0] status_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.LOCK_CYCLES(LOCK), .HALT_CODE(HC), .IDLE_CODE(IC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i), .stby_i(stby_i), .irq_i(irq_i),
    .nmi_i(nmi_i), .hold_req_i(hold_req_i), .bus_idle_i(bus_idle_i),
    .hold_ack_o(hold_ack_o), .pll_en_o(pll_en_o), .clk_en_o(clk_en_o),
    .status_oe_o(status_oe_o), .status_o(status_o));

  function automatic logic [7:0] mk(logic ce, logic pe, logic ha, logic oe, logic [3:0] st);
    return {ce, pe, ha, oe, st};
  endfunction

  localparam logic [7:0] E_RUN   = {4'b1101, IC};
  localparam logic [7:0] E_SLEEP = {4'b0101, HC};
  localparam logic [7:0] E_STOP  = {4'b0001, HC};
  localparam logic [7:0] E_LOCK  = {4'b0101, IC};

  function automatic logic [7:0] actual();
    return {clk_en_o, pll_en_o, hold_ack_o, status_oe_o, status_o};
  endfunction

  task automatic cmp(string tag, logic [7:0] exp);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, actual(), exp);
    end
  endtask

  // driver: inputs already set at negedge; push expectation for after next posedge
  task automatic step(string tag, logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) cmp(tag_q.pop_front(), exp_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    cmp("R1 reset state", E_RUN);
    @(negedge clk); rst_ni = 1'b1;
    step("R1 run after reset", E_RUN);
    halt_i = 1; step("R2 halt enters sleep", E_SLEEP);
    halt_i = 0; step("R2 sleep holds", E_SLEEP);
    irq_i = 1;  step("R4 irq wakes sleep", E_RUN);
    irq_i = 0; halt_i = 1; step("R2 sleep again", E_SLEEP);
    halt_i = 0; nmi_i = 1; step("R4 nmi edge wakes sleep", E_RUN);
    nmi_i = 0; hold_req_i = 1; bus_idle_i = 0; step("R8 busy run no grant", E_RUN);
    bus_idle_i = 1; step("R8 idle run grant", mk(1, 1, 1, 0, IC));
    hold_req_i = 0; bus_idle_i = 0; step("R9 run release", E_RUN);
    halt_i = 1; step("R2 enter sleep", E_SLEEP);
    halt_i = 0; hold_req_i = 1; step("R7 sleep grant", mk(0, 1, 1, 0, HC));
    step("R9 status released", mk(0, 1, 1, 0, HC));
    hold_req_i = 0; step("R9 halt code back", E_SLEEP);
    irq_i = 1; step("R4 wake", E_RUN);
    irq_i = 0; stby_i = 1; halt_i = 1; step("R3 stby priority stop", E_STOP);
    stby_i = 0; halt_i = 0; hold_req_i = 1; step("R7 no grant in stop", E_STOP);
    irq_i = 1; step("R5 irq ignored in stop", E_STOP);
    step("R5 still stop", E_STOP);
    irq_i = 0; hold_req_i = 0; nmi_i = 1; step("R6 nmi starts lock", E_LOCK);
    hold_req_i = 1;
    for (int i = 1; i < LOCK; i++) step("R6 lock wait gated", E_LOCK);
    hold_req_i = 0; step("R6 lock done run", E_RUN);
    stby_i = 1; step("R3 stop again", E_STOP);
    stby_i = 0; step("R11 held nmi no wake", E_STOP);
    nmi_i = 0; step("R11 nmi low", E_STOP);
    nmi_i = 1; step("R11 new edge wakes", E_LOCK);
    nmi_i = 0;
    for (int i = 1; i < LOCK; i++) step("R6 lock wait", E_LOCK);
    stby_i = 0; step("R6 run", E_RUN);
    stby_i = 1; step("R3 stop for reset", E_STOP);
    stby_i = 0;
    #1 rst_ni = 1'b0;
    #1 cmp("R10 async reset from stop", E_RUN);
    @(negedge clk); rst_ni = 1'b1;
    step("R10 run after reset", E_RUN);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule